// File: doc/BRIEF.md
# Stack Frame Access Shield

This block sits next to the data-stack load/store path and judges every stack access against three protection values: a read floor, a write floor and a frame-top bound. An access under the read floor (for loads) or under the write floor (for stores) is refused with a trap. An access at or beyond the frame top is not refused. Instead it is filtered. A load there returns a fixed canary word in place of the stale cached contents. A store there goes through, and it also asks the cache to drop every other word of the same line. The new word therefore needs no line fill, and nothing left by an earlier frame can be read back.

The three protection values are swapped at procedure boundaries. On a call, the current values are visible on the save outputs so that the control stack can keep them, and the new values are loaded at the same clock edge. On a return, the values taken back from the control stack are loaded. Every access gets a registered verdict one cycle after it is presented.

Top module: `shield_top`

## Requirements
- R1: After reset the read floor and the write floor are 0, the frame top is 32'hFFFF_FFFF, and rsp_valid, st_commit and inv_req are low.
- R2: A word-aligned load whose address is unsigned-below the read floor gives rsp_cause 1 and rsp_rdata 0.
- R3: A word-aligned store whose address is unsigned-below the write floor gives rsp_cause 2, with no st_commit and no inv_req.
- R4: A word-aligned load that is not trapped returns the canary word (default 32'hA5A5_5A5A) when its address is greater than or equal to the frame top. Otherwise it returns the cache_rdata value presented with the request. rsp_cause is 0 in both cases.
- R5: A word-aligned store that is not trapped, and whose address is greater than or equal to the frame top, gives st_commit and inv_req. inv_line is the address with its low five bits removed (address[31:5]). inv_keep has exactly bit address[4:2] set.
- R6: A word-aligned store that is not trapped and lies below the frame top gives st_commit with st_addr and st_data equal to the request, and no inv_req. A store response always carries rsp_rdata 0.
- R7: Any access with address[1:0] not zero gives rsp_cause 3, rsp_rdata 0, no st_commit and no inv_req. No floor or top check applies to it.
- R8: The floor checks take priority over the frame-top filter. An address that is below a floor and also at or above the top traps.
- R9: While call_en is high, the save outputs show the values in force before the call. At that edge the call values are loaded. An access presented in the same cycle is judged against the old values.
- R10: When ret_en is high and call_en is low, the ret values are loaded. When both are high, the call values win.
- R11: rsp_valid is high exactly in the cycle after a cycle with acc_valid high, and the verdict fields belong to that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Stack access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access byte address |
| acc_wdata | input | 32 | Store data |
| cache_rdata | input | 32 | Cached word for the load |
| call_en | input | 1 | Call: load call values |
| call_rd_floor | input | 32 | New read floor |
| call_wr_floor | input | 32 | New write floor |
| call_top | input | 32 | New frame top |
| ret_en | input | 1 | Return: load restored values |
| ret_rd_floor | input | 32 | Restored read floor |
| ret_wr_floor | input | 32 | Restored write floor |
| ret_top | input | 32 | Restored frame top |
| save_rd_floor | output | 32 | Current read floor |
| save_wr_floor | output | 32 | Current write floor |
| save_top | output | 32 | Current frame top |
| rsp_valid | output | 1 | Verdict valid |
| rsp_cause | output | 2 | 0 ok, 1 read floor, 2 write floor, 3 misaligned |
| rsp_rdata | output | 32 | Load value after filtering |
| st_commit | output | 1 | Store may be written to cache |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| inv_req | output | 1 | Partial line invalidation request |
| inv_line | output | 27 | Line address |
| inv_keep | output | 8 | Word kept in the line, one-hot |

## Verification
A frame swap and an access can land in the same cycle. The bench raises call_en together with a load, in a setup where the old and the new values give different verdicts for that load. It checks that the save outputs still show the old values before the edge, that the verdict follows the old values, and that a repeat of the same load traps under the new values. A call and a return are also raised together, to confirm that the call values are the ones loaded. Around these cases, exhaustive address sweeps in several floor and top setups, one of them with the floors above the top, check the priority between trapping and filtering.

// File: rtl/shield_pkg.sv
package shield_pkg;

    localparam int AW = 32;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_RSHIELD = 2'd1,
        CAUSE_WSHIELD = 2'd2,
        CAUSE_ALIGN   = 2'd3
    } cause_e;

    // Protection values of one frame
    typedef struct packed {
        logic [AW-1:0] rd_floor;
        logic [AW-1:0] wr_floor;
        logic [AW-1:0] top;
    } guard_t;

    // Verdict on one access
    typedef struct packed {
        logic          valid;
        cause_e        cause;
        logic          commit;
        logic          inv;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] rdata;
    } verdict_t;

    localparam guard_t GUARD_RESET = '{rd_floor: '0, wr_floor: '0, top: '1};

    function automatic logic word_aligned(input logic [AW-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

    function automatic logic below(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/shield_regs.sv
module shield_regs
    import shield_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   call_en,
    input  guard_t call_val,
    input  logic   ret_en,
    input  guard_t ret_val,
    output guard_t cur
);
    guard_t cur_q;

    always_ff @(posedge clk) begin
        if (rst)          cur_q <= GUARD_RESET;
        else if (call_en) cur_q <= call_val;
        else if (ret_en)  cur_q <= ret_val;
    end

    assign cur = cur_q;
endmodule

// File: rtl/shield_check.sv
module shield_check
    import shield_pkg::*;
#(
    parameter int            LINE_WORDS = 8,
    parameter logic [DW-1:0] CANARY     = 32'hA5A5_5A5A,
    localparam int           WSEL       = $clog2(LINE_WORDS),
    localparam int           LOFF       = WSEL + 2
) (
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [AW-1:0]       acc_addr,
    input  logic [DW-1:0]       acc_wdata,
    input  logic [DW-1:0]       cache_rdata,
    input  guard_t              g,
    output verdict_t            v,
    output logic [AW-LOFF-1:0]  line,
    output logic [LINE_WORDS-1:0] keep
);
    always_comb begin
        v       = '0;
        v.valid = acc_valid;
        v.cause = CAUSE_NONE;
        if (acc_valid) begin
            if (!word_aligned(acc_addr)) begin
                v.cause = CAUSE_ALIGN;
            end else if (acc_write) begin
                if (below(acc_addr, g.wr_floor)) begin
                    v.cause = CAUSE_WSHIELD;
                end else begin
                    v.commit = 1'b1;
                    v.addr   = acc_addr;
                    v.data   = acc_wdata;
                    v.inv    = !below(acc_addr, g.top);
                end
            end else begin
                if (below(acc_addr, g.rd_floor))   v.cause = CAUSE_RSHIELD;
                else if (!below(acc_addr, g.top))  v.rdata = CANARY;
                else                               v.rdata = cache_rdata;
            end
        end
    end

    assign line = v.inv ? acc_addr[AW-1:LOFF] : '0;

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_keep
        assign keep[w] = v.inv && (acc_addr[LOFF-1:2] == WSEL'(w));
    end
endmodule

// File: rtl/shield_resp.sv
module shield_resp
    import shield_pkg::*;
#(
    parameter int  LINE_WORDS = 8,
    localparam int LOFF       = $clog2(LINE_WORDS) + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  verdict_t              v_in,
    input  logic [AW-LOFF-1:0]    line_in,
    input  logic [LINE_WORDS-1:0] keep_in,
    output verdict_t              v_out,
    output logic [AW-LOFF-1:0]    line_out,
    output logic [LINE_WORDS-1:0] keep_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            v_out    <= '0;
            line_out <= '0;
            keep_out <= '0;
        end else begin
            v_out    <= v_in;
            line_out <= line_in;
            keep_out <= keep_in;
        end
    end
endmodule

// File: rtl/shield_top.sv
module shield_top
    import shield_pkg::*;
#(
    parameter int            LINE_WORDS = 8,
    parameter logic [31:0]   CANARY     = 32'hA5A5_5A5A,
    localparam int           LOFF       = $clog2(LINE_WORDS) + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [31:0]           acc_addr,
    input  logic [31:0]           acc_wdata,
    input  logic [31:0]           cache_rdata,
    input  logic                  call_en,
    input  logic [31:0]           call_rd_floor,
    input  logic [31:0]           call_wr_floor,
    input  logic [31:0]           call_top,
    input  logic                  ret_en,
    input  logic [31:0]           ret_rd_floor,
    input  logic [31:0]           ret_wr_floor,
    input  logic [31:0]           ret_top,
    output logic [31:0]           save_rd_floor,
    output logic [31:0]           save_wr_floor,
    output logic [31:0]           save_top,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_cause,
    output logic [31:0]           rsp_rdata,
    output logic                  st_commit,
    output logic [31:0]           st_addr,
    output logic [31:0]           st_data,
    output logic                  inv_req,
    output logic [31-LOFF+1-1:0]  inv_line,
    output logic [LINE_WORDS-1:0] inv_keep
);
    guard_t                cur;
    guard_t                call_val, ret_val;
    verdict_t              v_now, v_reg;
    logic [AW-LOFF-1:0]    line_now;
    logic [LINE_WORDS-1:0] keep_now;

    assign call_val = '{rd_floor: call_rd_floor, wr_floor: call_wr_floor, top: call_top};
    assign ret_val  = '{rd_floor: ret_rd_floor,  wr_floor: ret_wr_floor,  top: ret_top};

    shield_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .call_en  (call_en),
        .call_val (call_val),
        .ret_en   (ret_en),
        .ret_val  (ret_val),
        .cur      (cur)
    );

    shield_check #(.LINE_WORDS(LINE_WORDS), .CANARY(CANARY)) u_check (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .cache_rdata (cache_rdata),
        .g           (cur),
        .v           (v_now),
        .line        (line_now),
        .keep        (keep_now)
    );

    shield_resp #(.LINE_WORDS(LINE_WORDS)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .v_in     (v_now),
        .line_in  (line_now),
        .keep_in  (keep_now),
        .v_out    (v_reg),
        .line_out (inv_line),
        .keep_out (inv_keep)
    );

    assign save_rd_floor = cur.rd_floor;
    assign save_wr_floor = cur.wr_floor;
    assign save_top      = cur.top;

    assign rsp_valid = v_reg.valid;
    assign rsp_cause = v_reg.cause;
    assign rsp_rdata = v_reg.rdata;
    assign st_commit = v_reg.commit;
    assign st_addr   = v_reg.addr;
    assign st_data   = v_reg.data;
    assign inv_req   = v_reg.inv;
endmodule

// File: rtl/shield_chk.sv
module shield_chk #(
    parameter int  LINE_WORDS = 8,
    localparam int LOFF       = $clog2(LINE_WORDS) + 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  acc_valid,
    input logic                  acc_write,
    input logic [31:0]           acc_addr,
    input logic                  call_en,
    input logic [31:0]           call_rd_floor,
    input logic [31:0]           call_wr_floor,
    input logic [31:0]           call_top,
    input logic                  ret_en,
    input logic [31:0]           ret_rd_floor,
    input logic [31:0]           ret_wr_floor,
    input logic [31:0]           ret_top,
    input logic [31:0]           save_rd_floor,
    input logic [31:0]           save_wr_floor,
    input logic [31:0]           save_top,
    input logic                  rsp_valid,
    input logic [1:0]            rsp_cause,
    input logic [31:0]           rsp_rdata,
    input logic                  st_commit,
    input logic                  inv_req,
    input logic [LINE_WORDS-1:0] inv_keep
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(acc_valid)));

    a_r2_read_floor: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_valid && !acc_write && acc_addr[1:0] == 2'b00
                              && acc_addr < save_rd_floor)) |-> rsp_cause == 2'd1);

    a_r3_write_floor: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_valid && acc_write && acc_addr[1:0] == 2'b00
                              && acc_addr < save_wr_floor)) |-> (rsp_cause == 2'd2 && !st_commit));

    a_r7_misaligned: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_valid && acc_addr[1:0] != 2'b00)) |-> rsp_cause == 2'd3);

    a_r5_keep_onehot: assert property (@(posedge clk) disable iff (rst)
        inv_req |-> ($countones(inv_keep) == 1 && st_commit));

    a_r6_trap_quiet: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cause != 2'd0) |-> (!st_commit && !inv_req && rsp_rdata == 32'd0));

    a_r9_call_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(call_en)) |->
        (save_rd_floor == $past(call_rd_floor) && save_wr_floor == $past(call_wr_floor)
         && save_top == $past(call_top)));

    a_r10_ret_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ret_en && !call_en)) |->
        (save_rd_floor == $past(ret_rd_floor) && save_wr_floor == $past(ret_wr_floor)
         && save_top == $past(ret_top)));
endmodule

bind shield_top shield_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (.*);

// File: tb/sim_shield_top.sv
module sim_shield_top;
    localparam logic [31:0] CAN = 32'hA5A5_5A5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0, cache_rdata = '0;
    logic        call_en = 1'b0, ret_en = 1'b0;
    logic [31:0] call_rd_floor = '0, call_wr_floor = '0, call_top = '0;
    logic [31:0] ret_rd_floor = '0, ret_wr_floor = '0, ret_top = '0;
    logic [31:0] save_rd_floor, save_wr_floor, save_top;
    logic        rsp_valid, st_commit, inv_req;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_rdata, st_addr, st_data;
    logic [26:0] inv_line;
    logic [7:0]  inv_keep;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    shield_top u0 (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_call(input logic [31:0] r, input logic [31:0] w, input logic [31:0] t);
        @(negedge clk);
        call_en = 1'b1; call_rd_floor = r; call_wr_floor = w; call_top = t;
        @(negedge clk);
        call_en = 1'b0;
    endtask

    // Present one access, then check its verdict one cycle later
    task automatic access(input logic wr, input logic [31:0] a,
                          input logic [31:0] rf, input logic [31:0] wf, input logic [31:0] tp);
        logic [1:0]  e_cause;
        logic [31:0] e_rdata;
        logic        e_commit, e_inv;
        logic [7:0]  e_keep;
        string       tag;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        acc_wdata = ~a; cache_rdata = a ^ 32'h5A00_0000;
        e_cause = 2'd0; e_rdata = 32'd0; e_commit = 1'b0; e_inv = 1'b0; e_keep = 8'd0;
        if (a[1:0] != 2'b00) begin
            e_cause = 2'd3; tag = "R7";
        end else if (wr) begin
            if (a < wf) begin
                e_cause = 2'd2; tag = (a >= tp) ? "R8" : "R3";
            end else if (a >= tp) begin
                e_commit = 1'b1; e_inv = 1'b1; e_keep = 8'd1 << a[4:2]; tag = "R5";
            end else begin
                e_commit = 1'b1; tag = "R6";
            end
        end else begin
            if (a < rf) begin
                e_cause = 2'd1; tag = (a >= tp) ? "R8" : "R2";
            end else if (a >= tp) begin
                e_rdata = CAN; tag = "R4";
            end else begin
                e_rdata = a ^ 32'h5A00_0000; tag = "R4";
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
        chk(tag,
            {rsp_valid, rsp_cause, rsp_rdata, st_commit, (st_commit ? st_addr : 32'd0),
             (st_commit ? st_data : 32'd0), inv_req, (inv_req ? inv_line : 27'd0), inv_keep},
            {1'b1, e_cause, e_rdata, e_commit, (e_commit ? a : 32'd0),
             (e_commit ? ~a : 32'd0), e_inv, (e_inv ? a[31:5] : 27'd0), e_keep});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", {save_rd_floor, save_wr_floor, save_top, rsp_valid, st_commit, inv_req},
                  {32'd0, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        chk("R11", {96'd0, rsp_valid}, {96'd0, 1'b0});

        // Sweeps: read floor above write floor, write floor above read floor, floors over top
        do_call(32'h100, 32'h080, 32'h180);
        for (int a = 0; a < 512; a++) access(1'b0, 32'(a), 32'h100, 32'h080, 32'h180);
        for (int a = 0; a < 512; a++) access(1'b1, 32'(a), 32'h100, 32'h080, 32'h180);
        do_call(32'h040, 32'h120, 32'h1C0);
        for (int a = 0; a < 512; a++) access(1'b0, 32'(a), 32'h040, 32'h120, 32'h1C0);
        for (int a = 0; a < 512; a++) access(1'b1, 32'(a), 32'h040, 32'h120, 32'h1C0);
        do_call(32'h100, 32'h100, 32'h060);
        for (int a = 0; a < 512; a++) access(1'b0, 32'(a), 32'h100, 32'h100, 32'h060);
        for (int a = 0; a < 512; a++) access(1'b1, 32'(a), 32'h100, 32'h100, 32'h060);
        // High addresses: unsigned compare
        do_call(32'h8000_0000, 32'h8000_0000, 32'hFFFF_FF00);
        access(1'b0, 32'h7FFF_FFFC, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FF00);
        access(1'b0, 32'hFFFF_FFFC, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FF00);
        access(1'b1, 32'hFFFF_FFE4, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FF00);

        // R9: call in the same cycle as a load
        do_call(32'h100, 32'h080, 32'h180);
        @(negedge clk);
        call_en = 1'b1; call_rd_floor = 32'h1000; call_wr_floor = 32'h0800; call_top = 32'h2000;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h800; cache_rdata = 32'h1111_2222;
        #1;
        chk("R9", {32'd0, save_rd_floor, save_wr_floor, save_top},
                  {32'd0, 32'h100, 32'h080, 32'h180});
        @(negedge clk);
        call_en = 1'b0; acc_valid = 1'b0;
        chk("R9", {rsp_valid, rsp_cause, rsp_rdata}, {1'b1, 2'd0, CAN});
        chk("R9", {32'd0, save_rd_floor, save_wr_floor, save_top},
                  {32'd0, 32'h1000, 32'h0800, 32'h2000});
        access(1'b0, 32'h800, 32'h1000, 32'h0800, 32'h2000);

        // R10: call and return together -> call wins; then return alone
        @(negedge clk);
        call_en = 1'b1; call_rd_floor = 32'h10; call_wr_floor = 32'h20; call_top = 32'h30;
        ret_en = 1'b1; ret_rd_floor = 32'h44; ret_wr_floor = 32'h55; ret_top = 32'h66;
        @(negedge clk);
        call_en = 1'b0; ret_en = 1'b0;
        chk("R10", {32'd0, save_rd_floor, save_wr_floor, save_top}, {32'd0, 32'h10, 32'h20, 32'h30});
        @(negedge clk);
        ret_en = 1'b1; ret_rd_floor = 32'h100; ret_wr_floor = 32'h080; ret_top = 32'h180;
        @(negedge clk);
        ret_en = 1'b0;
        chk("R10", {32'd0, save_rd_floor, save_wr_floor, save_top}, {32'd0, 32'h100, 32'h080, 32'h180});
        access(1'b1, 32'h07C, 32'h100, 32'h080, 32'h180);
        @(negedge clk);
        chk("R11", {96'd0, rsp_valid}, {96'd0, 1'b0});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule